// File: doc/BRIEF.md
# Unaligned Row Fetch Aligner

This block rebuilds one row of eight-bit pixels that may begin at any byte address, using the 32-bit little-endian words that an aligned memory bus returns. For each row the caller supplies three consecutive aligned words and the two low bits of the row's start address. From these the block forms two 64-bit views. The first holds the eight pixels that start at the true start address. The second holds the same row moved right by one pixel, which a half-pixel horizontal filter needs. Both views are registered and carry a valid flag.

The block also keeps the row address. The caller loads a start address. After every row that is accepted, the address advances by a 16-bit stride. The block presents the word-aligned fetch address and the byte offset of the current row, so that the caller can issue the three word reads. Arbitration for the memory and any caching are outside this block.

Top module: `row_byte_aligner`

## Requirements
- R1: During reset and on the first clock after it, both valid flags are 0, both pixel views are all zeros, and the fetch address and row offset are 0.
- R2: In the unshifted view, bits 8k+7:8k hold byte (off+k) of the 12-byte little-endian string {word2, word1, word0}, for k = 0..7. Byte 0 is word0 bits 7:0, and byte 4 is word1 bits 7:0. Here off is the byte offset input, 0 to 3.
- R3: In the shifted view, bits 8k+7:8k hold byte (off+k+1) of the same string, for k = 0..7. Its low seven pixels therefore equal pixels 1 to 7 of the unshifted view.
- R4: With offset 0, word2 has no effect on the unshifted view, and word2 bits 7:0 appear in bits 63:56 of the shifted view.
- R5: When in_valid is high at a clock edge, both views and both valid flags are updated at that edge. When in_valid is low, both valid flags are 0 after the edge and both views keep their values.
- R6: fetch_addr equals the row address with its two low bits forced to 0. row_off equals the two low bits of the row address.
- R7: An edge with in_valid high and addr_load low adds the stride, zero-extended to 32 bits, to the row address, modulo 2^32. An edge with both signals low leaves the row address unchanged.
- R8: An edge with addr_load high sets the row address to addr_in, whatever the value of in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Load addr_in as the row address |
| addr_in | input | 32 | Start byte address of the first row |
| stride | input | 16 | Row stride in bytes, unsigned |
| fetch_addr | output | 32 | Word-aligned address of the first of the three words |
| row_off | output | 2 | Byte offset of the current row inside its first word |
| in_valid | input | 1 | The three words and the offset are present; accept a row |
| byte_off | input | 2 | Byte offset of the row being aligned |
| word0 | input | 32 | Word at fetch address + 0 |
| word1 | input | 32 | Word at fetch address + 4 |
| word2 | input | 32 | Word at fetch address + 8 |
| row_pix | output | 64 | Pixels 0..7 of the row, pixel 0 in bits 7:0 |
| row_pix_valid | output | 1 | row_pix was updated on the last edge |
| shift_pix | output | 64 | Pixels 1..8 of the row, pixel 1 in bits 7:0 |
| shift_pix_valid | output | 1 | shift_pix was updated on the last edge |

## Verification
The assertions treat in_valid, addr_load and the data inputs as settled and free of X at every sampled edge once reset has been released. They also expect reset to be held for at least one edge. The bench changes every input only on the falling clock edge and keeps all of them at defined values from time zero, so the assertions always see stable, known levels. The assertions place no limit on byte_off, because every 2-bit value is a legal offset. The bench drives all four offsets and several word patterns, including patterns in which only word2 changes.

// File: rtl/row_byte_aligner.sv
`timescale 1ns/1ps
module row_byte_aligner #(
  parameter int PIX_W    = 8,
  parameter int WORD_W   = 32,
  parameter int ROW_PIX  = 8,
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [STRIDE_W-1:0] stride,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [1:0]        row_off,
  input  logic              in_valid,
  input  logic [1:0]        byte_off,
  input  logic [WORD_W-1:0] word0,
  input  logic [WORD_W-1:0] word1,
  input  logic [WORD_W-1:0] word2,
  output logic [ROW_PIX*PIX_W-1:0] row_pix,
  output logic              row_pix_valid,
  output logic [ROW_PIX*PIX_W-1:0] shift_pix,
  output logic              shift_pix_valid
);
  localparam int ROW_W = ROW_PIX * PIX_W;
  localparam int CAT_W = 3 * WORD_W;

  logic [CAT_W-1:0]  fetched;
  logic [ROW_W-1:0]  row_next, shift_next;
  logic [ADDR_W-1:0] row_addr_q;

  assign fetched    = {word2, word1, word0};
  assign row_next   = ROW_W'(fetched >> (PIX_W * 32'(byte_off)));
  assign shift_next = ROW_W'(fetched >> (PIX_W * (32'(byte_off) + 1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_pix         <= '0;
      shift_pix       <= '0;
      row_pix_valid   <= 1'b0;
      shift_pix_valid <= 1'b0;
    end else begin
      row_pix_valid   <= in_valid;
      shift_pix_valid <= in_valid;
      if (in_valid) begin
        row_pix   <= row_next;
        shift_pix <= shift_next;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         row_addr_q <= '0;
    else if (addr_load) row_addr_q <= addr_in;
    else if (in_valid)  row_addr_q <= row_addr_q + ADDR_W'(stride);
  end

  assign fetch_addr = {row_addr_q[ADDR_W-1:2], 2'b00};
  assign row_off    = row_addr_q[1:0];

  p_valid_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (row_pix_valid && shift_pix_valid));
  p_valid_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!row_pix_valid && !shift_pix_valid));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(row_pix) && $stable(shift_pix)));
  p_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    row_pix_valid |-> (shift_pix[ROW_W-PIX_W-1:0] == row_pix[ROW_W-1:PIX_W]));
  p_off0_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && byte_off == 2'd0) |=> (shift_pix[ROW_W-1:ROW_W-PIX_W] == $past(word2[PIX_W-1:0])));
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> ({fetch_addr[ADDR_W-1:2], row_off} == $past(addr_in)));
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_load && !in_valid) |=> ($stable(fetch_addr) && $stable(row_off)));
  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_load && in_valid) |=>
      ({fetch_addr[ADDR_W-1:2], row_off} == $past({fetch_addr[ADDR_W-1:2], row_off} + ADDR_W'(stride))));
endmodule

// File: tb/test_row_byte_aligner.sv
`timescale 1ns/1ps
module test_row_byte_aligner;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_load = 1'b0;
  logic [31:0] addr_in = '0;
  logic [15:0] stride = '0;
  logic [31:0] fetch_addr;
  logic [1:0] row_off;
  logic in_valid = 1'b0;
  logic [1:0] byte_off = '0;
  logic [31:0] word0 = '0, word1 = '0, word2 = '0;
  logic [63:0] row_pix, shift_pix;
  logic row_pix_valid, shift_pix_valid;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  row_byte_aligner i_row_byte_aligner (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .stride(stride), .fetch_addr(fetch_addr), .row_off(row_off),
    .in_valid(in_valid), .byte_off(byte_off), .word0(word0), .word1(word1),
    .word2(word2), .row_pix(row_pix), .row_pix_valid(row_pix_valid),
    .shift_pix(shift_pix), .shift_pix_valid(shift_pix_valid));

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] pick(logic [31:0] a, logic [31:0] b, logic [31:0] c, int idx);
    logic [31:0] w;
    w = (idx < 4) ? a : (idx < 8) ? b : c;
    return w[8*(idx%4) +: 8];
  endfunction

  function automatic logic [63:0] expect_row(logic [31:0] a, logic [31:0] b, logic [31:0] c, int first);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = pick(a, b, c, first + k);
    return r;
  endfunction

  task automatic send(logic [1:0] off, logic [31:0] a, logic [31:0] b, logic [31:0] c);
    @(negedge clk);
    in_valid = 1'b1; byte_off = off; word0 = a; word1 = b; word2 = c;
    @(posedge clk); #1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 row valid", 64'(row_pix_valid), 64'd0);
    chk("R1 shift valid", 64'(shift_pix_valid), 64'd0);
    chk("R1 row data", row_pix, 64'd0);
    chk("R1 shift data", shift_pix, 64'd0);
    chk("R1 fetch addr", 64'(fetch_addr), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 row valid after release", 64'(row_pix_valid), 64'd0);
    chk("R1 offset", 64'(row_off), 64'd0);
  endtask

  task automatic t_offsets();
    logic [31:0] pa [3];
    pa = '{32'h03020100, 32'h07060504, 32'h0B0A0908};
    for (int o = 0; o < 4; o++) begin
      send(2'(o), pa[0], pa[1], pa[2]);
      chk($sformatf("R2 offset %0d row", o), row_pix, expect_row(pa[0], pa[1], pa[2], o));
      chk($sformatf("R3 offset %0d shift", o), shift_pix, expect_row(pa[0], pa[1], pa[2], o + 1));
    end
    pa = '{32'hDEADBEEF, 32'h80FF7F01, 32'hA55AC33C};
    for (int o = 0; o < 4; o++) begin
      send(2'(o), pa[0], pa[1], pa[2]);
      chk($sformatf("R2 pattern offset %0d row", o), row_pix, expect_row(pa[0], pa[1], pa[2], o));
      chk($sformatf("R3 pattern offset %0d shift", o), shift_pix, expect_row(pa[0], pa[1], pa[2], o + 1));
    end
  endtask

  task automatic t_off0_third_word();
    send(2'd0, 32'h44332211, 32'h88776655, 32'h000000AA);
    chk("R4 row without word2 a", row_pix, 64'h8877665544332211);
    chk("R4 shift pixel 8 a", shift_pix, 64'hAA88776655443322);
    send(2'd0, 32'h44332211, 32'h88776655, 32'hFFFFFF5C);
    chk("R4 row without word2 b", row_pix, 64'h8877665544332211);
    chk("R4 shift pixel 8 b", shift_pix, 64'h5C88776655443322);
  endtask

  task automatic t_latency_hold();
    logic [63:0] r0, s0;
    @(negedge clk);
    in_valid = 1'b1; byte_off = 2'd2;
    word0 = 32'h11111111; word1 = 32'h22222222; word2 = 32'h33333333;
    chk("R5 valid low before edge", 64'(row_pix_valid), 64'd0);
    @(posedge clk); #1;
    chk("R5 row valid one cycle later", 64'(row_pix_valid), 64'd1);
    chk("R5 shift valid one cycle later", 64'(shift_pix_valid), 64'd1);
    chk("R5 data one cycle later", row_pix, 64'h3333222222221111);
    r0 = row_pix; s0 = shift_pix;
    @(negedge clk);
    in_valid = 1'b0; byte_off = 2'd1;
    word0 = 32'hCAFEF00D; word1 = 32'h0; word2 = 32'hFFFFFFFF;
    @(posedge clk); #1;
    chk("R5 valid drops", 64'(row_pix_valid), 64'd0);
    chk("R5 row held", row_pix, r0);
    chk("R5 shift held", shift_pix, s0);
  endtask

  task automatic t_address();
    @(negedge clk);
    addr_load = 1'b1; addr_in = 32'h0000_1235; stride = 16'd40;
    @(posedge clk); #1;
    @(negedge clk); addr_load = 1'b0;
    chk("R8 load fetch addr", 64'(fetch_addr), 64'h1234);
    chk("R6 row offset", 64'(row_off), 64'd1);
    @(posedge clk); #1;
    chk("R7 idle keeps address", 64'(fetch_addr), 64'h1234);
    send(2'd1, 32'h0, 32'h0, 32'h0);
    chk("R7 advance fetch addr", 64'(fetch_addr), 64'h125C);
    chk("R6 offset after advance", 64'(row_off), 64'd1);
    stride = 16'd3;
    send(2'd1, 32'h0, 32'h0, 32'h0);
    chk("R6 aligned fetch addr", 64'(fetch_addr), 64'h1260);
    chk("R6 offset moves", 64'(row_off), 64'd0);
  endtask

  task automatic t_load_priority();
    @(negedge clk);
    addr_load = 1'b1; in_valid = 1'b1; addr_in = 32'h0000_1003; stride = 16'h0100;
    @(posedge clk); #1;
    @(negedge clk); addr_load = 1'b0; in_valid = 1'b0;
    chk("R8 load beats advance addr", 64'(fetch_addr), 64'h1000);
    chk("R8 load beats advance offset", 64'(row_off), 64'd3);
  endtask

  task automatic t_wrap();
    @(negedge clk);
    addr_load = 1'b1; addr_in = 32'hFFFF_FFFE; stride = 16'hFFFF;
    @(posedge clk); #1;
    @(negedge clk); addr_load = 1'b0;
    send(2'd2, 32'h0, 32'h0, 32'h0);
    chk("R7 wrap fetch addr", 64'(fetch_addr), 64'h0000_FFFC);
    chk("R7 wrap offset", 64'(row_off), 64'd1);
  endtask

  initial begin
    t_reset();
    t_offsets();
    t_off0_third_word();
    t_latency_hold();
    t_address();
    t_load_priority();
    t_wrap();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule